// File: doc/BRIEF.md
# Four-Channel DMA Control Register Hub

This block is the software-facing register set of a multi-channel DMA controller. Several independent software owners each drive one channel. The block lets each owner start or stop its channel, reconfigure it and acknowledge its events with a single write. No read-modify-write sequence is needed, so no owner can disturb another channel. Every shared register that holds per-channel state pairs each value bit or field with a mask bit. A write changes only the channels whose mask bit is one. The status register clears only the bits that are written as one.

The channel engines report completion, terminal-count and error events on per-channel pulse inputs. These events set status bits and end the channel's run state without software involvement. If an event and a clear hit the same bit in the same cycle, the event wins. A single combined interrupt line is high while any enabled channel has a pending status bit.

Register addresses:

| Address | Register |
|---|---|
| 0 | run control |
| 1 | status |
| 2 | polarity |
| 3 | interrupt enable |
| 4+c | control word of channel c |

In every masked register, the mask bit of channel c is data bit 16+c. Reads are combinational from the addressed register.

Top module: `dma_reg_hub`

## Requirements
- R1: A write to address 0 with data bit 16+c and data bit c both one sets run_en[c] in the cycle after the write edge.
- R2: A write to address 0 with data bit 16+c one and data bit c zero clears run_en[c] in the cycle after the write edge.
- R3: A write to address 0 leaves run_en[c] unchanged for every channel whose data bit 16+c is zero, whatever data bit c holds.
- R4: A completion or error pulse on channel c clears run_en[c] at the next edge. The exception is a masked write to address 0 for that channel in the same cycle, whose value then takes effect.
- R5: Reading address 0 returns run_en in bits [3:0] and zero in every other bit, including the mask positions.
- R6: Status bit 4c holds channel c completion, bit 4c+1 its terminal count and bit 4c+2 its error. Bit 4c+3 always reads zero. An event pulse sets its bit at the next edge.
- R7: Writing address 1 clears exactly the status bits written as one. Bits written as zero are untouched.
- R8: An event and a clear of the same status bit in the same cycle leave the bit set.
- R9: The polarity register holds a 4-bit field per channel at bits [4c+3:4c], driven on chan_pol. A write to address 2 updates field c only when data bit 16+c is one.
- R10: The interrupt enable register is written at address 3 with value bit c and mask bit 16+c. irq is high exactly while some channel c has its enable set and any of its status bits set.
- R11: Address 4+c holds channel c's 32-bit control word. A write replaces it, a read returns it, and chan_ctrl carries it at bits [32c+31:32c]. Addresses 8 to 15 read as zero.
- R12: After reset, run_en, all status, polarity, enable and control words are zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data of the addressed register |
| evt_done | input | 4 | Per-channel completion pulse |
| evt_tc | input | 4 | Per-channel terminal-count pulse |
| evt_err | input | 4 | Per-channel error pulse |
| run_en | output | 4 | Per-channel run enable |
| chan_pol | output | 16 | Per-channel polarity fields |
| chan_ctrl | output | 128 | Per-channel control words |
| irq | output | 1 | Combined interrupt |

## Verification
The run register is driven with all 256 combinations of value and mask nibbles, starting from whatever state the previous write left. This separates a correct masked update from one that ignores the mask or writes every channel. All 4096 combinations of completion, terminal-count and error pulses are applied, each together with a changing clear pattern. That sweep tells apart event-over-clear priority, clear-only-ones behaviour and the self-clearing of run bits. The polarity and enable registers get full mask sweeps, and the enable sweep also checks the interrupt line. Control words and unmapped reads are checked once per address.

// File: rtl/dma_reg_pkg.sv
// Package: shared address map and field layout of the DMA register hub.
// Assumes at most 16 channels so mask bits fit above bit 16.
package dma_reg_pkg;
    localparam int unsigned MASK_LSB  = 16;
    localparam int unsigned ADR_RUN   = 0;
    localparam int unsigned ADR_STAT  = 1;
    localparam int unsigned ADR_POL   = 2;
    localparam int unsigned ADR_IEN   = 3;
    localparam int unsigned ADR_CTRL0 = 4;
    localparam int unsigned ST_DONE   = 0;
    localparam int unsigned ST_TC     = 1;
    localparam int unsigned ST_ERR    = 2;
    localparam int unsigned ST_STRIDE = 4;
endpackage

// File: rtl/dma_masked_fields.sv
// Module: bank of NUM_F fields of FW bits, each updated only when its own
// mask bit accompanies a write. Assumes one write per cycle at most.
module dma_masked_fields #(
    parameter int unsigned NUM_F = 4,
    parameter int unsigned FW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [NUM_F*FW-1:0]   val,
    input  logic [NUM_F-1:0]      msk,
    output logic [NUM_F*FW-1:0]   q
);
    for (genvar f = 0; f < NUM_F; f++) begin : g_fld
        // Holds field f; replaced only on a write that selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[f*FW +: FW] <= '0;
            else if (wr && msk[f])
                q[f*FW +: FW] <= val[f*FW +: FW];
        end
    end
endmodule

// File: rtl/dma_run_ctl.sv
// Module: per-channel run enables. A masked write sets or clears a channel;
// a stop event ends the run unless a masked write to that channel coincides.
module dma_run_ctl #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [NUM_CH-1:0] val,
    input  logic [NUM_CH-1:0] msk,
    input  logic [NUM_CH-1:0] stop_evt,
    output logic [NUM_CH-1:0] run
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Run state of channel c: write has priority over self-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                run[c] <= 1'b0;
            else if (wr && msk[c])
                run[c] <= val[c];
            else if (stop_evt[c])
                run[c] <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_evt_status.sv
// Module: per-channel sticky event flags with write-one-to-clear.
// A same-cycle event beats a clear. Output uses the package stride layout.
module dma_evt_status #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned STRIDE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        clr_done,
    input  logic [NUM_CH-1:0]        clr_tc,
    input  logic [NUM_CH-1:0]        clr_err,
    input  logic [NUM_CH-1:0]        evt_done,
    input  logic [NUM_CH-1:0]        evt_tc,
    input  logic [NUM_CH-1:0]        evt_err,
    output logic [NUM_CH*STRIDE-1:0] stat
);
    import dma_reg_pkg::*;
    logic [NUM_CH-1:0] done_q, tc_q, err_q;

    // Sticky flags: keep unless cleared, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
            tc_q   <= '0;
            err_q  <= '0;
        end else begin
            done_q <= (done_q & ~clr_done) | evt_done;
            tc_q   <= (tc_q   & ~clr_tc)   | evt_tc;
            err_q  <= (err_q  & ~clr_err)  | evt_err;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lay
        // Place channel c flags in its status slot; unused bits read zero.
        always_comb begin
            stat[c*STRIDE +: STRIDE]   = '0;
            stat[c*STRIDE + ST_DONE]   = done_q[c];
            stat[c*STRIDE + ST_TC]     = tc_q[c];
            stat[c*STRIDE + ST_ERR]    = err_q[c];
        end
    end
endmodule

// File: rtl/dma_reg_hub.sv
// Module: top of the DMA register hub. Decodes the register bus, holds the
// per-channel control words, builds read data and the combined interrupt.
// Assumes NUM_CH*POL_W <= 16, NUM_CH*4 <= 16, CTRL_W <= DATA_W, and enough
// address bits for 4+NUM_CH registers.
module dma_reg_hub #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned POL_W  = 4,
    parameter int unsigned CTRL_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    input  logic                     reg_wr,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NUM_CH-1:0]        evt_done,
    input  logic [NUM_CH-1:0]        evt_tc,
    input  logic [NUM_CH-1:0]        evt_err,
    output logic [NUM_CH-1:0]        run_en,
    output logic [NUM_CH*POL_W-1:0]  chan_pol,
    output logic [NUM_CH*CTRL_W-1:0] chan_ctrl,
    output logic                     irq
);
    import dma_reg_pkg::*;
    localparam int unsigned STAT_W = NUM_CH * ST_STRIDE;

    logic               sel_run, sel_stat, sel_pol, sel_ien;
    logic [NUM_CH-1:0]  wmask;
    logic [NUM_CH-1:0]  clr_done, clr_tc, clr_err;
    logic [STAT_W-1:0]  stat_q;
    logic [NUM_CH-1:0]  ien_q;
    logic [NUM_CH-1:0]  irq_src;
    logic [CTRL_W-1:0]  ctrl_q [NUM_CH];

    // Address decode for the shared registers.
    assign sel_run  = (reg_addr == ADDR_W'(ADR_RUN));
    assign sel_stat = (reg_addr == ADDR_W'(ADR_STAT));
    assign sel_pol  = (reg_addr == ADDR_W'(ADR_POL));
    assign sel_ien  = (reg_addr == ADDR_W'(ADR_IEN));
    assign wmask    = reg_wdata[MASK_LSB +: NUM_CH];

    // Per-channel clear strobes taken from the status write data.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            clr_done[c] = reg_wr && sel_stat && reg_wdata[c*ST_STRIDE + ST_DONE];
            clr_tc[c]   = reg_wr && sel_stat && reg_wdata[c*ST_STRIDE + ST_TC];
            clr_err[c]  = reg_wr && sel_stat && reg_wdata[c*ST_STRIDE + ST_ERR];
        end
    end

    dma_run_ctl #(.NUM_CH(NUM_CH)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr && sel_run),
        .val      (reg_wdata[NUM_CH-1:0]),
        .msk      (wmask),
        .stop_evt (evt_done | evt_err),
        .run      (run_en)
    );

    dma_evt_status #(.NUM_CH(NUM_CH), .STRIDE(ST_STRIDE)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_done (clr_done),
        .clr_tc   (clr_tc),
        .clr_err  (clr_err),
        .evt_done (evt_done),
        .evt_tc   (evt_tc),
        .evt_err  (evt_err),
        .stat     (stat_q)
    );

    dma_masked_fields #(.NUM_F(NUM_CH), .FW(POL_W)) u_pol (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr && sel_pol),
        .val   (reg_wdata[NUM_CH*POL_W-1:0]),
        .msk   (wmask),
        .q     (chan_pol)
    );

    dma_masked_fields #(.NUM_F(NUM_CH), .FW(1)) u_ien (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr && sel_ien),
        .val   (reg_wdata[NUM_CH-1:0]),
        .msk   (wmask),
        .q     (ien_q)
    );

    // Control words: plain full-width registers, one address each.
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CH; c++) begin
            if (!rst_n)
                ctrl_q[c] <= '0;
            else if (reg_wr && reg_addr == ADDR_W'(ADR_CTRL0 + c))
                ctrl_q[c] <= reg_wdata[CTRL_W-1:0];
        end
    end

    // Flatten control words onto the output bus.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            chan_ctrl[c*CTRL_W +: CTRL_W] = ctrl_q[c];
    end

    // Interrupt: any pending status bit of an enabled channel.
    always_comb begin
        for (int c = 0; c < NUM_CH; c++)
            irq_src[c] = ien_q[c] && (|stat_q[c*ST_STRIDE +: ST_STRIDE]);
    end
    assign irq = |irq_src;

    // Read mux; mask positions and unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        if (sel_run)
            reg_rdata = DATA_W'(run_en);
        else if (sel_stat)
            reg_rdata = DATA_W'(stat_q);
        else if (sel_pol)
            reg_rdata = DATA_W'(chan_pol);
        else if (sel_ien)
            reg_rdata = DATA_W'(ien_q);
        else begin
            for (int c = 0; c < NUM_CH; c++)
                if (reg_addr == ADDR_W'(ADR_CTRL0 + c))
                    reg_rdata = DATA_W'(ctrl_q[c]);
        end
    end
endmodule

// File: rtl/dma_reg_hub_chk.sv
// Module: temporal checks on the register hub, attached by bind.
// Assumes the package register map and status layout.
module dma_reg_hub_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned POL_W  = 4,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [DATA_W-1:0]       reg_wdata,
    input logic                    reg_wr,
    input logic [NUM_CH-1:0]       evt_done,
    input logic [NUM_CH-1:0]       evt_tc,
    input logic [NUM_CH-1:0]       evt_err,
    input logic [NUM_CH-1:0]       run_en,
    input logic [NUM_CH*POL_W-1:0] chan_pol,
    input logic                    irq,
    input logic [NUM_CH*4-1:0]     stat_vec
);
    import dma_reg_pkg::*;
    localparam int unsigned SW = NUM_CH * ST_STRIDE;

    logic [NUM_CH-1:0] run_msk, run_val, pol_msk, stop_evt;
    logic [SW-1:0]     ev_vec, clr_vec;
    logic              ien_wr;

    assign run_msk  = (reg_wr && reg_addr == ADDR_W'(ADR_RUN)) ? reg_wdata[MASK_LSB +: NUM_CH] : '0;
    assign run_val  = reg_wdata[NUM_CH-1:0];
    assign pol_msk  = (reg_wr && reg_addr == ADDR_W'(ADR_POL)) ? reg_wdata[MASK_LSB +: NUM_CH] : '0;
    assign clr_vec  = (reg_wr && reg_addr == ADDR_W'(ADR_STAT)) ? reg_wdata[SW-1:0] : '0;
    assign ien_wr   = reg_wr && reg_addr == ADDR_W'(ADR_IEN);
    assign stop_evt = evt_done | evt_err;

    // Gather the event pulses into the status layout.
    always_comb begin
        ev_vec = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            ev_vec[c*ST_STRIDE + ST_DONE] = evt_done[c];
            ev_vec[c*ST_STRIDE + ST_TC]   = evt_tc[c];
            ev_vec[c*ST_STRIDE + ST_ERR]  = evt_err[c];
        end
    end

    // R1
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_msk & run_val) & ~run_en) == '0);
    // R2
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_msk & ~run_val) & run_en) == '0);
    // R3
    unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_en ^ $past(run_en)) & ~$past(run_msk) & ~$past(stop_evt)) == '0);
    // R4
    self_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop_evt & ~run_msk) & run_en) == '0);
    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ev_vec) & ~stat_vec) == '0);
    // R7
    clear_only_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_vec) & ~stat_vec & ~$past(clr_vec)) == '0);
    // R10
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(ien_wr) || $past(|ev_vec)));
    // R12
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (run_en == '0 && !irq && stat_vec == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_pol
        // R9
        pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(pol_msk[c]) |-> $stable(chan_pol[c*POL_W +: POL_W]));
    end
endmodule

bind dma_reg_hub dma_reg_hub_chk #(
    .NUM_CH (NUM_CH),
    .POL_W  (POL_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .evt_done  (evt_done),
    .evt_tc    (evt_tc),
    .evt_err   (evt_err),
    .run_en    (run_en),
    .chan_pol  (chan_pol),
    .irq       (irq),
    .stat_vec  (stat_q)
);

// File: tb/dma_reg_hub_bench.sv
// Bench: sweeps of the masked registers and event/clear combinations,
// compared against a model built from the requirements.
module dma_reg_hub_bench;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  evt_done = '0, evt_tc = '0, evt_err = '0;
    logic [N-1:0]  run_en;
    logic [15:0]   chan_pol;
    logic [127:0]  chan_ctrl;
    logic          irq;

    logic [N-1:0]  m_run = '0, m_ien = '0;
    logic [15:0]   m_stat = '0, m_pol = '0;
    logic [127:0]  m_ctrl = '0;
    int            vecs = 0, bad = 0;
    bit            finished = 0;

    always #2 clk = ~clk;

    dma_reg_hub u_dma_reg_hub (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .evt_done(evt_done),
        .evt_tc(evt_tc), .evt_err(evt_err), .run_en(run_en),
        .chan_pol(chan_pol), .chan_ctrl(chan_ctrl), .irq(irq)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int c = 0; c < N; c++)
            if (m_ien[c] && (m_stat[c*4 +: 4] != 4'd0)) r = 1'b1;
        return r;
    endfunction

    // One cycle of stimulus; model updated per the requirements.
    task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] dn, input logic [3:0] tc, input logic [3:0] er);
        logic [15:0] clr, ev;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        evt_done = dn; evt_tc = tc; evt_err = er;
        @(posedge clk);
        m_run = m_run & ~(dn | er);                          // R4
        if (wr && a == 4'd0)
            for (int c = 0; c < N; c++) if (d[16+c]) m_run[c] = d[c];   // R1 R2 R3
        clr = (wr && a == 4'd1) ? d[15:0] : 16'd0;
        ev = '0;
        for (int c = 0; c < N; c++) begin                    // R6
            ev[c*4]   = dn[c];
            ev[c*4+1] = tc[c];
            ev[c*4+2] = er[c];
        end
        m_stat = (m_stat & ~clr) | ev;                       // R7 R8
        if (wr && a == 4'd2)
            for (int c = 0; c < N; c++) if (d[16+c]) m_pol[c*4 +: 4] = d[c*4 +: 4];  // R9
        if (wr && a == 4'd3)
            for (int c = 0; c < N; c++) if (d[16+c]) m_ien[c] = d[c];  // R10
        for (int c = 0; c < N; c++)
            if (wr && a == 4'(4 + c)) m_ctrl[c*32 +: 32] = d;  // R11
        #1;
        reg_wr = 1'b0; evt_done = '0; evt_tc = '0; evt_err = '0;
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, 128'(reg_rdata), 128'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #1;
        // R12: reset state
        chk("R12 run", 128'(run_en), 128'd0);
        chk("R12 irq", 128'(irq), 128'd0);
        chk("R12 pol", 128'(chan_pol), 128'd0);
        chk("R12 ctrl", chan_ctrl, 128'd0);
        for (int a = 0; a < 8; a++) rd("R12 read", 4'(a), 32'd0);

        // R1 R2 R3 R5: every value/mask nibble pair on the run register
        for (int p = 0; p < 256; p++) begin
            step(1'b1, 4'd0, {12'(p * 29), 4'(p >> 4), 12'(p * 7), 4'(p)}, '0, '0, '0);
            chk("R1/R2/R3 run_en", 128'(run_en), 128'(m_run));
            rd("R5 run readback", 4'd0, {28'd0, m_run});
        end

        // R4: stop events against running channels, with a racing write
        for (int p = 0; p < 256; p++) begin
            step(1'b1, 4'd0, 32'h000F_000F, '0, '0, '0);
            step(1'b1, 4'd0, {12'd0, 4'(p * 53 >> 4), 12'd0, 4'(p * 53)},
                 4'(p), 4'(p >> 2), 4'(p >> 4));
            chk("R4 self stop", 128'(run_en), 128'(m_run));
        end

        // R6 R8 R10: all event combinations with a moving clear pattern
        for (int e = 0; e < 4096; e++) begin
            if ((e % 256) == 0)
                step(1'b1, 4'd3, {12'd0, 4'hF, 12'd0, 4'(e >> 8)}, '0, '0, '0);
            step(1'b1, 4'd1, {16'hFFFF, 16'(e * 97 + 13)}, 4'(e), 4'(e >> 4), 4'(e >> 8));
            chk("R10 irq", 128'(irq), 128'(exp_irq()));
            rd("R6/R8 status", 4'd1, {16'd0, m_stat});
        end

        // R7: clear single bits with no events pending
        step(1'b0, 4'd0, 32'd0, 4'hF, 4'hF, 4'hF);
        for (int b = 0; b < 16; b++) begin
            step(1'b1, 4'd1, 32'(1) << b, '0, '0, '0);
            rd("R7 w1c", 4'd1, {16'd0, m_stat});
        end

        // R10: enable sweep with some status pending
        for (int p = 0; p < 256; p++) begin
            if ((p % 16) == 0) step(1'b0, 4'd0, 32'd0, 4'(p >> 4), 4'd0, 4'd0);
            step(1'b1, 4'd3, {12'hABC, 4'(p >> 4), 12'h123, 4'(p)}, '0, '0, '0);
            chk("R10 irq vs enable", 128'(irq), 128'(exp_irq()));
            rd("R10 enable readback", 4'd3, {28'd0, m_ien});
            if ((p % 32) == 31) begin
                step(1'b1, 4'd1, 32'h0000_FFFF, '0, '0, '0);
                chk("R10 irq after clear", 128'(irq), 128'd0);
            end
        end

        // R9: polarity fields under all masks
        for (int p = 0; p < 256; p++) begin
            step(1'b1, 4'd2, {12'd0, 4'(p >> 4), 16'(p * 40503)}, '0, '0, '0);
            chk("R9 pol", 128'(chan_pol), 128'(m_pol));
            rd("R9 pol readback", 4'd2, {16'd0, m_pol});
        end

        // R11: control words and unmapped addresses
        for (int c = 0; c < N; c++)
            step(1'b1, 4'(4 + c), 32'hC0DE_0000 ^ (32'h1357_9BDF * (c + 1)), '0, '0, '0);
        chk("R11 ctrl bus", chan_ctrl, m_ctrl);
        for (int c = 0; c < N; c++) rd("R11 ctrl readback", 4'(4 + c), m_ctrl[c*32 +: 32]);
        for (int a = 8; a < 16; a++) begin
            step(1'b1, 4'(a), 32'hFFFF_FFFF, '0, '0, '0);
            rd("R11 unmapped", 4'(a), 32'd0);
        end
        chk("R11 ctrl untouched", chan_ctrl, m_ctrl);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule